// File: doc/BRIEF.md
# Panel Self-Refresh State Sequencer

This block tracks one display pipe through the states of panel self-refresh. Software drives a small control register over a single-cycle write strobe. The register holds an enable bit, a timer-mode field, a transmitter-state bit, an active-entry request and a single-frame-update request. The block reports a three-bit state code, an in-transition flag and a self-refresh-active flag. The control fields can be read back on dedicated outputs.

Some moves are made by software: turning the block on, requesting entry and clearing entry. Others the block makes on its own at a frame-boundary pulse: settling into the active state, finishing a single-frame update, and returning to inactive after the sink has acknowledged a wake. When the entry request is withdrawn, the block goes straight to exit and never passes through the single-frame state. A single-frame request clears itself when the block arrives in the active state.

The state machine acts on the registered control fields. A register write therefore changes the control outputs at the next edge and the state one edge after that.

Top module: `selfrefresh_ctrl`

## Requirements
- R1: The state code is 0 off, 1 inactive, 2 entering (static frame sent), 3 active with no buffer update, 4 active with single-frame update, 5 exiting. `sr_active` is high exactly in states 3 and 4. `in_transition` is high exactly in states 2, 4 and 5.
- R2: From state 0 the block moves only to state 1. It does so one edge after the register holds enable=1, mode=1 (software timer) and transmitter bit=1. Any other mode value, or a clear transmitter bit, keeps it in state 0. An entry request alone never starts entry from state 0.
- R3: In state 1, a held entry request moves the block to state 2. In state 2 it moves to state 3 at the next edge that carries a frame pulse, and stays in state 2 on edges without one.
- R4: A cleared entry request in state 2, 3 or 4 moves the block to state 5 at the next edge, without visiting state 4.
- R5: State 5 returns to state 1 only at a frame pulse after `wake_ack` has been seen while in state 5. Frame pulses without a wake leave it in state 5.
- R6: In state 3 with the single-frame request set, the block moves to state 4. State 4 returns to state 3 at the next frame pulse.
- R7: The single-frame request bit clears at the edge on which the block arrives in state 3.
- R8: A write with the enable bit clear zeroes enable, entry, single-frame, transmitter and mode fields together.
- R9: Whenever the registered enable is low, the state is 0 after the next edge.
- R10: Reset forces state 0 and clears every control field.
- R11: A single-frame request written together with enable=0 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_enable | input | 1 | Enable bit to write |
| wr_entry | input | 1 | Active-entry request to write |
| wr_sfu | input | 1 | Writing 1 requests a single-frame update |
| wr_xmit | input | 1 | Transmitter-state bit to write |
| wr_mode | input | MODE_W | Mode field to write (1 = software timer) |
| frame_tick | input | 1 | One-cycle frame-boundary pulse |
| wake_ack | input | 1 | Sink wake acknowledge |
| ctl_enable | output | 1 | Stored enable bit |
| ctl_entry | output | 1 | Stored entry request |
| ctl_sfu | output | 1 | Stored single-frame request |
| ctl_xmit | output | 1 | Stored transmitter-state bit |
| ctl_mode | output | MODE_W | Stored mode field |
| state_code | output | 3 | Current state code |
| in_transition | output | 1 | High in states 2, 4, 5 |
| sr_active | output | 1 | High in states 3, 4 |

## Verification
The embedded properties check these rules on every cycle: the forced drop to state 0 when enable is low, that state 0 can only lead to state 1, the skip from 3 straight to 5, holding in exit until a frame pulse, the automatic 2-to-3 advance, the self-clearing request, and the all-fields clear on disable. The bench scenarios cover the rest. They cover whole sequences that need several writes and pulses in order: a wake seen before the frame pulse, the wrong mode or transmitter bit leaving the block off, a request written while disabled being dropped, and reset in the middle of an active sequence.

// File: rtl/srf_pkg.sv
package srf_pkg;
    localparam int SRF_STATE_W = 3;

    typedef enum logic [SRF_STATE_W-1:0] {
        ST_OFF    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_ENTER  = 3'd2,
        ST_ACTIVE = 3'd3,
        ST_SFU    = 3'd4,
        ST_EXIT   = 3'd5
    } srf_state_e;
endpackage

// File: rtl/srf_ctl_regs.sv
module srf_ctl_regs #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_enable,
    input  logic              wr_entry,
    input  logic              wr_sfu,
    input  logic              wr_xmit,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic              arrive_active_i,
    output logic              enable_o,
    output logic              entry_o,
    output logic              sfu_o,
    output logic              xmit_o,
    output logic [MODE_W-1:0] mode_o
);
    typedef struct packed {
        logic              enable;
        logic              entry;
        logic              sfu;
        logic              xmit;
        logic [MODE_W-1:0] mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (arrive_active_i) begin
            ctl_d.sfu = 1'b0;
        end
        if (wr_en) begin
            if (wr_enable) begin
                ctl_d.enable = 1'b1;
                ctl_d.entry  = wr_entry;
                ctl_d.xmit   = wr_xmit;
                ctl_d.mode   = wr_mode;
                if (wr_sfu) begin
                    ctl_d.sfu = 1'b1;
                end
            end else begin
                ctl_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign enable_o = ctl_q.enable;
    assign entry_o  = ctl_q.entry;
    assign sfu_o    = ctl_q.sfu;
    assign xmit_o   = ctl_q.xmit;
    assign mode_o   = ctl_q.mode;

    // R8: a disabling write zeroes every field together
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_enable |=> !enable_o && !entry_o && !sfu_o && !xmit_o && mode_o == '0);

    // R7: the single-frame request drops on arrival in the active state
    a_r7_sfu_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        arrive_active_i && !wr_en |=> !sfu_o);
endmodule

// File: rtl/srf_fsm.sv
module srf_fsm
    import srf_pkg::*;
#(
    parameter int          MODE_W       = 2,
    parameter int unsigned MODE_SWTIMER = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              entry_i,
    input  logic              sfu_i,
    input  logic              xmit_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              frame_tick_i,
    input  logic              wake_ack_i,
    output srf_state_e        state_o,
    output logic              arrive_active_o
);
    typedef struct packed {
        srf_state_e st;
        logic       woke;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (!enable_i) begin
            fsm_d.st = ST_OFF;
        end else begin
            unique case (fsm_q.st)
                ST_OFF: begin
                    if (mode_i == MODE_W'(MODE_SWTIMER) && xmit_i) fsm_d.st = ST_IDLE;
                end
                ST_IDLE: begin
                    if (entry_i) fsm_d.st = ST_ENTER;
                end
                ST_ENTER: begin
                    if (!entry_i)          fsm_d.st = ST_EXIT;
                    else if (frame_tick_i) fsm_d.st = ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (!entry_i)   fsm_d.st = ST_EXIT;
                    else if (sfu_i) fsm_d.st = ST_SFU;
                end
                ST_SFU: begin
                    if (!entry_i)          fsm_d.st = ST_EXIT;
                    else if (frame_tick_i) fsm_d.st = ST_ACTIVE;
                end
                ST_EXIT: begin
                    if (frame_tick_i && (fsm_q.woke || wake_ack_i)) fsm_d.st = ST_IDLE;
                end
                default: fsm_d.st = ST_OFF;
            endcase
        end
        fsm_d.woke = (fsm_d.st == ST_EXIT) &&
                     (fsm_q.woke || (fsm_q.st == ST_EXIT && wake_ack_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_OFF, woke: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o         = fsm_q.st;
    assign arrive_active_o = (fsm_d.st == ST_ACTIVE) && (fsm_q.st != ST_ACTIVE);

    // R9: disabled means off after the next edge
    a_r9_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> state_o == ST_OFF);

    // R2: off can only lead to inactive
    a_r2_off_exit: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == ST_OFF |=> (state_o == ST_OFF || state_o == ST_IDLE));

    // R3: entering settles to active on a frame pulse
    a_r3_auto_settle: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i && entry_i && state_o == ST_ENTER && frame_tick_i |=> state_o == ST_ACTIVE);

    // R4: withdrawn entry in active skips straight to exit
    a_r4_skip_sfu: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i && !entry_i && state_o == ST_ACTIVE |=> state_o == ST_EXIT);

    // R5: exit holds until a frame pulse
    a_r5_exit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i && state_o == ST_EXIT && !frame_tick_i |=> state_o == ST_EXIT);
endmodule

// File: rtl/srf_status.sv
module srf_status
    import srf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  srf_state_e state_i,
    output logic       in_trans_o,
    output logic       active_o
);
    always_comb begin
        in_trans_o = (state_i == ST_ENTER) || (state_i == ST_SFU) || (state_i == ST_EXIT);
        active_o   = (state_i == ST_ACTIVE) || (state_i == ST_SFU);
    end

    // R1: both flags together only in the single-frame state
    a_r1_flag_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        in_trans_o && active_o |-> state_i == ST_SFU);
endmodule

// File: rtl/selfrefresh_ctrl.sv
module selfrefresh_ctrl
    import srf_pkg::*;
#(
    parameter int          MODE_W       = 2,
    parameter int unsigned MODE_SWTIMER = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_enable,
    input  logic                   wr_entry,
    input  logic                   wr_sfu,
    input  logic                   wr_xmit,
    input  logic [MODE_W-1:0]      wr_mode,
    input  logic                   frame_tick,
    input  logic                   wake_ack,
    output logic                   ctl_enable,
    output logic                   ctl_entry,
    output logic                   ctl_sfu,
    output logic                   ctl_xmit,
    output logic [MODE_W-1:0]      ctl_mode,
    output logic [SRF_STATE_W-1:0] state_code,
    output logic                   in_transition,
    output logic                   sr_active
);
    srf_state_e cur_state;
    logic       arrive_active;

    srf_ctl_regs #(.MODE_W(MODE_W)) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_enable       (wr_enable),
        .wr_entry        (wr_entry),
        .wr_sfu          (wr_sfu),
        .wr_xmit         (wr_xmit),
        .wr_mode         (wr_mode),
        .arrive_active_i (arrive_active),
        .enable_o        (ctl_enable),
        .entry_o         (ctl_entry),
        .sfu_o           (ctl_sfu),
        .xmit_o          (ctl_xmit),
        .mode_o          (ctl_mode)
    );

    srf_fsm #(.MODE_W(MODE_W), .MODE_SWTIMER(MODE_SWTIMER)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .enable_i        (ctl_enable),
        .entry_i         (ctl_entry),
        .sfu_i           (ctl_sfu),
        .xmit_i          (ctl_xmit),
        .mode_i          (ctl_mode),
        .frame_tick_i    (frame_tick),
        .wake_ack_i      (wake_ack),
        .state_o         (cur_state),
        .arrive_active_o (arrive_active)
    );

    srf_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (cur_state),
        .in_trans_o (in_transition),
        .active_o   (sr_active)
    );

    assign state_code = cur_state;
endmodule

// File: tb/tb_selfrefresh_ctrl.sv
`timescale 1ns/1ps
module tb_selfrefresh_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, wr_enable = 0, wr_entry = 0, wr_sfu = 0, wr_xmit = 0;
    logic [1:0] wr_mode = 2'd0;
    logic       frame_tick = 0, wake_ack = 0;
    logic       ctl_enable, ctl_entry, ctl_sfu, ctl_xmit;
    logic [1:0] ctl_mode;
    logic [2:0] state_code;
    logic       in_transition, sr_active;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #10 clk = ~clk;

    selfrefresh_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_enable(wr_enable),
        .wr_entry(wr_entry), .wr_sfu(wr_sfu), .wr_xmit(wr_xmit), .wr_mode(wr_mode),
        .frame_tick(frame_tick), .wake_ack(wake_ack), .ctl_enable(ctl_enable),
        .ctl_entry(ctl_entry), .ctl_sfu(ctl_sfu), .ctl_xmit(ctl_xmit),
        .ctl_mode(ctl_mode), .state_code(state_code),
        .in_transition(in_transition), .sr_active(sr_active)
    );

    // {wr, en, entry, sfu, mode[1:0], xmit, tick, wake, exp_state[2:0], exp_sfu}
    localparam int NV = 25;
    localparam logic [12:0] VEC [0:NV-1] = '{
        13'b1_1_0_0_01_1_0_0_000_0, // enable written, state lags one edge
        13'b0_0_0_0_00_0_0_0_001_0, // R2 off -> inactive
        13'b0_0_0_0_00_0_1_0_001_0, // R2 no entry by itself
        13'b1_1_1_0_01_1_0_0_001_0,
        13'b0_0_0_0_00_0_0_0_010_0, // R3 inactive -> entering
        13'b0_0_0_0_00_0_0_0_010_0, // R3 waits for a frame pulse
        13'b0_0_0_0_00_0_1_0_011_0, // R3 entering -> active
        13'b1_1_1_1_01_1_0_0_011_1,
        13'b0_0_0_0_00_0_0_0_100_1, // R6 active -> single-frame
        13'b0_0_0_0_00_0_0_0_100_1,
        13'b0_0_0_0_00_0_1_0_011_0, // R6 R7 back to active, request cleared
        13'b0_0_0_0_00_0_0_0_011_0,
        13'b1_1_0_0_01_1_0_0_011_0,
        13'b0_0_0_0_00_0_0_0_101_0, // R4 active -> exit directly
        13'b0_0_0_0_00_0_1_0_101_0, // R5 pulse without wake holds
        13'b0_0_0_0_00_0_0_1_101_0, // R5 wake alone holds
        13'b0_0_0_0_00_0_1_0_001_0, // R5 pulse after wake -> inactive
        13'b0_0_0_0_00_0_0_0_001_0,
        13'b1_0_1_1_01_1_0_0_001_0, // R8 R11 disabling write
        13'b0_0_0_0_00_0_0_0_000_0, // R9 forced off
        13'b0_0_0_0_00_0_0_0_000_0,
        13'b1_1_0_0_10_1_0_0_000_0, // R2 wrong mode
        13'b0_0_0_0_00_0_0_0_000_0,
        13'b1_1_0_0_01_0_0_0_000_0, // R2 transmitter bit clear
        13'b0_0_0_0_00_0_0_0_000_0
    };

    task automatic check(input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic en, input logic ent, input logic sf,
                        input logic [1:0] md, input logic xm, input logic tk, input logic wk);
        wr_en = w; wr_enable = en; wr_entry = ent; wr_sfu = sf;
        wr_mode = md; wr_xmit = xm; frame_tick = tk; wake_ack = wk;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; frame_tick = 0; wake_ack = 0;
    endtask

    task automatic check_state(input string what, input int exp_st);
        check({what, " state"}, state_code, exp_st);
        check({what, " R1 in_transition"}, in_transition,
              (exp_st == 2 || exp_st == 4 || exp_st == 5) ? 1 : 0);
        check({what, " R1 sr_active"}, sr_active, (exp_st == 3 || exp_st == 4) ? 1 : 0);
    endtask

    task automatic bring_to_active();
        step(1, 1, 1, 0, 2'd1, 1, 0, 0);
        step(0, 0, 0, 0, 2'd0, 0, 0, 0);
        step(0, 0, 0, 0, 2'd0, 0, 0, 0);
        step(0, 0, 0, 0, 2'd0, 0, 1, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check_state("R10 reset", 0);
        check("R10 reset enable", ctl_enable, 0);
        check("R10 reset sfu", ctl_sfu, 0);
        check("R10 reset mode", ctl_mode, 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9],
                 VEC[i][8:7], VEC[i][6], VEC[i][5], VEC[i][4]);
            check_state($sformatf("R2 R3 R4 R5 R6 R9 vec%0d", i), int'(VEC[i][3:1]));
            check($sformatf("R7 R11 vec%0d sfu", i), ctl_sfu, int'(VEC[i][0]));
        end

        // R8: disabling write clears every stored field
        step(1, 1, 1, 0, 2'd1, 1, 0, 0);
        step(1, 0, 1, 1, 2'd3, 1, 0, 0);
        check("R8 enable", ctl_enable, 0);
        check("R8 entry", ctl_entry, 0);
        check("R8 xmit", ctl_xmit, 0);
        check("R8 mode", ctl_mode, 0);
        check("R11 sfu", ctl_sfu, 0);
        step(0, 0, 0, 0, 2'd0, 0, 0, 0);
        check_state("R9 after disable", 0);

        // R4: entry withdrawn while entering goes to exit
        step(1, 1, 1, 0, 2'd1, 1, 0, 0);
        step(0, 0, 0, 0, 2'd0, 0, 0, 0);
        step(0, 0, 0, 0, 2'd0, 0, 0, 0);
        check_state("R3 entering", 2);
        step(1, 1, 0, 0, 2'd1, 1, 0, 0);
        step(0, 0, 0, 0, 2'd0, 0, 0, 0);
        check_state("R4 entering to exit", 5);

        // R9: disable from active
        step(1, 0, 0, 0, 2'd0, 0, 0, 0);
        step(0, 0, 0, 0, 2'd0, 0, 0, 0);
        bring_to_active();
        check_state("R3 active again", 3);
        step(1, 0, 0, 0, 2'd0, 0, 0, 0);
        check_state("R9 one edge after write", 3);
        step(0, 0, 0, 0, 2'd0, 0, 0, 0);
        check_state("R9 forced off from active", 0);

        // R10: reset in the middle of a single-frame update
        bring_to_active();
        step(1, 1, 1, 1, 2'd1, 1, 0, 0);
        step(0, 0, 0, 0, 2'd0, 0, 0, 0);
        check_state("R6 single-frame", 4);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_state("R10 mid-sequence reset", 0);
        check("R10 sfu cleared", ctl_sfu, 0);
        check("R10 entry cleared", ctl_entry, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule